// File: doc/BRIEF.md
# Audio Clock Divider Chain

This block derives two clocks for one audio direction from a single source clock. The first is the master clock, used as a high-rate reference. The second is the serial bit clock. Three counting stages are chained together. The first is a prescaler that either passes every source cycle or divides by eight. The second is a modulus stage that divides by 1 to 256. The third is a fine stage that divides by 1 to 16 and feeds only the bit clock. Each output level toggles on its stage's strobe, and that toggling is the fixed divide-by-two of the chain. Software computes the divisor values and writes them through a small register-style port. The block only counts, multiplexes and applies polarity.

Two bypass paths exist. In master bypass the source clock drives the master clock output directly, with every divider skipped. In fine-only mode the bit clock is taken from the fine stage, which then counts source cycles and ignores the prescaler and modulus. Polarity bits invert the bit clock and master clock levels, and a direction bit drives the master clock pad enable. New divisor values are adopted by each stage only when that stage wraps, so a period in progress always finishes at its old length.

Top module: `aclk_div_chain`

## Requirements
- R1: While `rst` is high, `hck_en`, `sck_en`, `hck_out`, `sck_out` and `hck_oe` are all low.
- R2: A write with `cfg_addr`=0 sets the divisor register: bits [7:0] hold M-1, bits [11:8] hold F-1 and bit 12 selects the prescaler (0 gives P=1, 1 gives P=8). Outside master bypass, `hck_en` pulses for one cycle every P×M source cycles.
- R3: The modulus stage covers its full range: with M=1 and P=1 `hck_en` is high every cycle, and M=256 gives a 256-cycle pulse interval.
- R4: Outside fine-only mode, `sck_en` pulses every P×M×F source cycles, and each such pulse coincides with an `hck_en` pulse.
- R5: A write with `cfg_addr`=1 sets the control register. When bit 1 (fine-only) is set, `sck_en` pulses every F source cycles whatever P and M are.
- R6: When control bit 0 (master bypass) is set, `hck_en` is high in every cycle and `hck_out` follows the source clock, inverted if the master polarity is inverted.
- R7: Outside master bypass, `hck_out` changes level one cycle after each `hck_en` pulse, and `sck_out` changes level one cycle after each `sck_en` pulse. The output clock period is therefore twice the pulse interval.
- R8: `hck_oe` equals control bit 2 from the cycle after the write.
- R9: Control bit 3 inverts both `sck_out` and `hck_out`. Control bit 4 inverts `hck_out` alone. A write to the divisor register leaves the control register unchanged.
- R10: After a divisor write, the interval that is in progress completes with the old value, and every later interval uses the new value. No shorter pulse interval appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock; every stage counts its cycles |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | 0 selects the divisor register, 1 the control register |
| cfg_wdata | input | 13 | Write data |
| hck_en | output | 1 | Master clock strobe, one per half period |
| hck_out | output | 1 | Master clock level after polarity, or the source clock in bypass |
| hck_oe | output | 1 | Master clock pad drive enable |
| sck_en | output | 1 | Bit clock strobe, one per half period |
| sck_out | output | 1 | Bit clock level after polarity |

## Verification
Both strobes are decoded from registered counters. A strobe is therefore visible in the cycle where its counter sits at its terminal value, and the output level changes on the rising edge after it. A register write lands on the edge after `cfg_we`, while new divisors wait for each stage's own wrap. For this reason the bench never predicts absolute cycle numbers after a reconfiguration. It waits out a settling window sized from the old and new ratios, then compares the spacing of successive strobes. The reload check is the one exception. It starts measuring on the exact strobe whose wrap coincides with the write, so the first interval must carry the old divisor. Inputs change 1 ns after the rising edge and outputs are sampled on the falling edge. Polarity is checked against a count of edges since reset, because with unit divisors the levels toggle every cycle.

// File: rtl/aclk_pkg.sv
`timescale 1ns/1ps
package aclk_pkg;

    localparam int MOD_W     = 8;
    localparam int FINE_W    = 4;
    localparam int PRE_RATIO = 8;
    localparam int PRE_W     = $clog2(PRE_RATIO);
    localparam int CFG_W     = MOD_W + FINE_W + 1;

    typedef enum logic {
        REG_DIV = 1'b0,
        REG_CTL = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic              pre_div8;
        logic [FINE_W-1:0] fine_m1;
        logic [MOD_W-1:0]  mod_m1;
    } div_cfg_t;

    typedef struct packed {
        logic hck_inv_only;
        logic bclk_inv;
        logic hck_drive;
        logic fine_only;
        logic hck_bypass;
    } ctl_cfg_t;

    localparam int CTL_W = $bits(ctl_cfg_t);

    function automatic div_cfg_t decode_div(input logic [CFG_W-1:0] w);
        div_cfg_t d;
        d.mod_m1   = w[MOD_W-1:0];
        d.fine_m1  = w[MOD_W+FINE_W-1:MOD_W];
        d.pre_div8 = w[MOD_W+FINE_W];
        return d;
    endfunction

    function automatic ctl_cfg_t decode_ctl(input logic [CFG_W-1:0] w);
        return ctl_cfg_t'(w[CTL_W-1:0]);
    endfunction

endpackage

// File: rtl/aclk_cfg_regs.sv
`timescale 1ns/1ps
module aclk_cfg_regs
    import aclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic             addr,
    input  logic [CFG_W-1:0] wdata,
    output div_cfg_t         div_q,
    output ctl_cfg_t         ctl_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            ctl_q <= '0;
        end else if (we) begin
            case (reg_sel_e'(addr))
                REG_DIV: div_q <= decode_div(wdata);
                REG_CTL: ctl_q <= decode_ctl(wdata);
                default: ;
            endcase
        end
    end

    // R9
    ctl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (we && addr == REG_DIV) |=> $stable(ctl_q));

endmodule

// File: rtl/aclk_count_stage.sv
`timescale 1ns/1ps
module aclk_count_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    input  logic [W-1:0] lim_next,
    output logic         tick
);

    logic [W-1:0] cnt;
    logic [W-1:0] lim;

    assign tick = adv && !rst && (cnt == lim);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            lim <= '0;
        end else if (adv) begin
            if (cnt == lim) begin
                cnt <= '0;
                lim <= lim_next;
            end else begin
                cnt <= cnt + W'(1);
            end
        end
    end

    // R3
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= lim);

    // R10
    lim_at_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (lim != $past(lim)) |-> $past(tick));

endmodule

// File: rtl/aclk_level_gen.sv
`timescale 1ns/1ps
module aclk_level_gen (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic inv,
    output logic lvl
);

    logic q;

    always_ff @(posedge clk) begin
        if (rst)       q <= 1'b0;
        else if (tick) q <= ~q;
    end

    assign lvl = q ^ inv;

    // R1
    reset_low_chk: assert property (@(posedge clk)
        rst |=> !q);

    // R7
    toggle_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> (q != $past(q)));

endmodule

// File: rtl/aclk_div_chain.sv
`timescale 1ns/1ps
module aclk_div_chain
    import aclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic             cfg_addr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic             hck_en,
    output logic             hck_out,
    output logic             hck_oe,
    output logic             sck_en,
    output logic             sck_out
);

    div_cfg_t          div_c;
    ctl_cfg_t          ctl_c;
    logic [PRE_W-1:0]  pre_lim_next;
    logic              pre_tick;
    logic              mod_tick;
    logic              fine_adv;
    logic              fine_tick;
    logic              hck_inv;
    logic              hck_lvl;

    aclk_cfg_regs u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .div_q (div_c),
        .ctl_q (ctl_c)
    );

    assign pre_lim_next = div_c.pre_div8 ? PRE_W'(PRE_RATIO - 1) : '0;

    aclk_count_stage #(.W(PRE_W)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .adv      (1'b1),
        .lim_next (pre_lim_next),
        .tick     (pre_tick)
    );

    aclk_count_stage #(.W(MOD_W)) u_mod (
        .clk      (clk),
        .rst      (rst),
        .adv      (pre_tick),
        .lim_next (div_c.mod_m1),
        .tick     (mod_tick)
    );

    assign fine_adv = ctl_c.fine_only ? 1'b1 : mod_tick;

    aclk_count_stage #(.W(FINE_W)) u_fine (
        .clk      (clk),
        .rst      (rst),
        .adv      (fine_adv),
        .lim_next (div_c.fine_m1),
        .tick     (fine_tick)
    );

    assign hck_inv = ctl_c.bclk_inv ^ ctl_c.hck_inv_only;

    aclk_level_gen u_hck_lvl (
        .clk  (clk),
        .rst  (rst),
        .tick (mod_tick),
        .inv  (hck_inv),
        .lvl  (hck_lvl)
    );

    aclk_level_gen u_sck_lvl (
        .clk  (clk),
        .rst  (rst),
        .tick (fine_tick),
        .inv  (ctl_c.bclk_inv),
        .lvl  (sck_out)
    );

    assign hck_en  = ctl_c.hck_bypass | mod_tick;
    assign hck_out = ctl_c.hck_bypass ? (clk ^ hck_inv) : hck_lvl;
    assign hck_oe  = ctl_c.hck_drive;
    assign sck_en  = fine_tick;

    // R4
    sck_on_hck_chk: assert property (@(posedge clk) disable iff (rst)
        (sck_en && !ctl_c.fine_only) |-> mod_tick);

    // R2
    pre_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (pre_tick && div_c.pre_div8 && $past(div_c.pre_div8) && !$past(pre_tick))
            |=> !pre_tick);

endmodule

// File: tb/aclk_div_chain_tb.sv
`timescale 1ns/1ps
module aclk_div_chain_tb;

    localparam int CLK_PERIOD   = 10;
    localparam int WATCHDOG_CYC = 200000;

    logic        clk       = 1'b0;
    logic        rst       = 1'b1;
    logic        cfg_we    = 1'b0;
    logic        cfg_addr  = 1'b0;
    logic [12:0] cfg_wdata = '0;
    logic        hck_en, hck_out, hck_oe, sck_en, sck_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    aclk_div_chain u_dut (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .hck_en    (hck_en),
        .hck_out   (hck_out),
        .hck_oe    (hck_oe),
        .sck_en    (sck_en),
        .sck_out   (sck_out)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int now     = 0;
    int cyc     = 0;
    int prev_max = 1;

    always @(posedge clk) begin
        now <= now + 1;
        cyc <= rst ? 0 : cyc + 1;
    end

    // scoreboard state
    int    exp_h[$];
    int    exp_s[$];
    bit    arm_h = 0, arm_s = 0;
    int    last_h = 0, last_s = 0;
    string tag_h = "R2", tag_s = "R4";
    bit    lvl_h_on = 0, lvl_s_on = 0;
    bit    pend_h = 0, pend_s = 0;
    logic  prev_h = 0, prev_s = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic finish_up();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // monitor: pops expected intervals as strobes appear
    always @(negedge clk) begin
        int e;
        if (!rst) begin
            if (lvl_h_on && pend_h) begin
                check(hck_out != prev_h, "R7", int'(hck_out), int'(!prev_h));
                pend_h = 0;
            end
            if (lvl_s_on && pend_s) begin
                check(sck_out != prev_s, "R7", int'(sck_out), int'(!prev_s));
                pend_s = 0;
            end
            if (hck_en) begin
                if (arm_h) begin
                    arm_h = 0;
                end else if (exp_h.size() > 0) begin
                    e = exp_h.pop_front();
                    check((now - last_h) == e, tag_h, now - last_h, e);
                end
                if (lvl_h_on && exp_h.size() > 0) begin
                    prev_h = hck_out;
                    pend_h = 1;
                end
                last_h = now;
            end
            if (sck_en) begin
                if (arm_s) begin
                    arm_s = 0;
                end else if (exp_s.size() > 0) begin
                    e = exp_s.pop_front();
                    check((now - last_s) == e, tag_s, now - last_s, e);
                end
                if (lvl_s_on && exp_s.size() > 0) begin
                    prev_s = sck_out;
                    pend_s = 1;
                end
                last_s = now;
            end
        end
    end

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr(input bit a, input int d);
        cfg_we    = 1'b1;
        cfg_addr  = a;
        cfg_wdata = 13'(d);
        step(1);
        cfg_we    = 1'b0;
    endtask

    function automatic int div_word(input bit p8, input int m, input int f);
        return (int'(p8) << 12) | ((f - 1) << 8) | (m - 1);
    endfunction

    // driver: program, settle, push expected intervals, wait for the monitor
    task automatic run(input bit p8, input int m, input int f, input int ctl,
                       input int eh, input int es, input int n,
                       input string th, input string ts);
        int settle;
        wr(1'b0, div_word(p8, m, f));
        wr(1'b1, ctl);
        settle = prev_max + 17 * eh + 2 * es + 8;
        step(settle);
        tag_h    = th;
        tag_s    = ts;
        lvl_h_on = ((ctl & 1) == 0);
        lvl_s_on = 1'b1;
        arm_h    = 1'b1;
        arm_s    = 1'b1;
        for (int i = 0; i < n; i++) begin
            exp_h.push_back(eh);
            exp_s.push_back(es);
        end
        while (exp_h.size() > 0 || exp_s.size() > 0) step(1);
        step(1);
        lvl_h_on = 1'b0;
        lvl_s_on = 1'b0;
        pend_h   = 1'b0;
        pend_s   = 1'b0;
        prev_max = (eh > es) ? eh : es;
    endtask

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        check(1'b0, "watchdog", now, WATCHDOG_CYC);
        finish_up();
    end

    initial begin
        step(3);
        // R1: everything low in reset
        check(hck_en  == 1'b0, "R1", int'(hck_en),  0);
        check(sck_en  == 1'b0, "R1", int'(sck_en),  0);
        check(hck_out == 1'b0, "R1", int'(hck_out), 0);
        check(sck_out == 1'b0, "R1", int'(sck_out), 0);
        check(hck_oe  == 1'b0, "R1", int'(hck_oe),  0);
        rst = 1'b0;
        step(2);

        // R2 / R4 normal chain
        run(1'b0,   3,  2, 0,    3,    6, 4, "R2", "R4");
        run(1'b1,   2,  3, 0,   16,   48, 3, "R2", "R4");
        // R3 modulus boundaries
        run(1'b0,   1,  1, 0,    1,    1, 4, "R3", "R4");
        run(1'b0, 256,  1, 0,  256,  256, 3, "R3", "R4");
        // R4 fine maximum
        run(1'b0,   2, 16, 0,    2,   32, 3, "R2", "R4");
        run(1'b1, 256,  1, 0, 2048, 2048, 2, "R2", "R4");
        // R5 fine-only (control bit 1)
        run(1'b0,   5, 16, 2,    5,   16, 4, "R2", "R5");
        run(1'b1,   3,  1, 2,   24,    1, 4, "R2", "R5");
        // R6 master bypass (bit 0) with master-only invert (bit 4)
        run(1'b0,   4,  3, 17,   1,   12, 4, "R6", "R4");
        check(hck_out == 1'b0, "R6", int'(hck_out), 0);
        #(CLK_PERIOD/2);
        check(hck_out == 1'b1, "R6", int'(hck_out), 1);
        @(posedge clk);
        #1;

        // R10: rewrite modulus on the strobe whose wrap coincides with the write
        run(1'b0,   3,  1, 0,    3,    3, 3, "R2", "R4");
        while (!hck_en) step(1);
        tag_h = "R10";
        arm_h = 1'b1;
        exp_h.push_back(3);
        exp_h.push_back(10);
        exp_h.push_back(10);
        wr(1'b0, div_word(1'b0, 10, 1));
        while (exp_h.size() > 0) step(1);

        // R9 polarity with unit divisors: levels toggle each cycle after reset
        rst = 1'b1;
        step(2);
        rst = 1'b0;
        wr(1'b1, 8);
        for (int k = 0; k < 2; k++) begin
            check(sck_out == ((cyc % 2) ^ 1), "R9", int'(sck_out), (cyc % 2) ^ 1);
            check(hck_out == ((cyc % 2) ^ 1), "R9", int'(hck_out), (cyc % 2) ^ 1);
            step(1);
        end
        wr(1'b1, 16);
        check(sck_out == (cyc % 2),       "R9", int'(sck_out), cyc % 2);
        check(hck_out == ((cyc % 2) ^ 1), "R9", int'(hck_out), (cyc % 2) ^ 1);
        wr(1'b1, 24);
        check(sck_out == ((cyc % 2) ^ 1), "R9", int'(sck_out), (cyc % 2) ^ 1);
        check(hck_out == (cyc % 2),       "R9", int'(hck_out), cyc % 2);
        wr(1'b0, div_word(1'b0, 1, 1));
        check(sck_out == ((cyc % 2) ^ 1), "R9", int'(sck_out), (cyc % 2) ^ 1);

        // R8 pad direction
        wr(1'b1, 4);
        check(hck_oe == 1'b1, "R8", int'(hck_oe), 1);
        wr(1'b1, 0);
        check(hck_oe == 1'b0, "R8", int'(hck_oe), 0);

        finish_up();
    end

endmodule